// File: doc/BRIEF.md
# Multi-Policy Register Bit-Field Cell

This block holds a bank of control/status fields for a memory-mapped peripheral. Each field has its own software access policy, picked at elaboration time from a fixed set. The policies are: plain read/write, read-only, write-only, clear on written 0, clear on written 1, clear on any write, clear on read, set on read, set on written 1, write-once, toggle on written 1, write-1-trigger, and reserved. A simple register-bus port drives the bank: select, write enable, read enable, write data, per-bit write mask and combinational read data. Each field reacts to that traffic according to its policy.

The hardware side has a per-bit set, clear and load (enable plus value) for every stored field. It sees the stored values on a flat output. Write-1-trigger bits drive a one-cycle pulse output. Field i occupies data bits [FIELD_W*i +: FIELD_W]. Its policy code sits in bits [4*i +: 4] of the policy vector, and its reset value is the matching slice of the reset vector. The reset is synchronous and active-high.

Top module: `multipolicy_reg`

## Requirements
- R1: Policy codes are 0 read/write, 1 read-only, 2 write-only, 3 clear-on-0, 4 clear-on-1, 5 clear-on-any-write, 6 clear-on-read, 7 set-on-read, 8 set-on-1, 9 write-once, 10 toggle, 11 write-1-trigger, 12 reserved. On the clock edge with reset high, every stored bit takes its reset value, every write-once lock is released and the trigger output goes to 0.
- R2: A bus write is `sel && wr_en`, and it acts only on bits whose mask bit is 1. A read/write bit loads the write data. A read-only bit ignores every write. Both read back their stored value.
- R3: A write-only bit loads the write data as a read/write bit does, but reads always return its reset value, not the stored value.
- R4: A clear-on-0 bit goes to 0 when a masked write carries 0 in that bit and is unchanged by a 1. A clear-on-1 bit goes to 0 when a masked write carries 1 and is unchanged by a 0.
- R5: A clear-on-any-write bit goes to 0 on every masked write, whatever the data.
- R6: A read is `sel && rd_en`. A clear-on-read or set-on-read bit returns its value from before the read, then goes to 0 (or to 1) on the clock edge ending the read. Writes do not change either kind.
- R7: A set-on-1 bit goes to 1 when a masked write carries 1 and is unchanged by a 0.
- R8: A write-once field takes the first write after reset that has at least one mask bit set within that field. From then on, software writes to that field are ignored until the next reset.
- R9: A toggle bit inverts when a masked write carries 1 and is unchanged by a 0.
- R10: A masked write of 1 to a write-1-trigger bit raises that bit of `trig` for exactly the cycle after the write edge. Software never changes its stored value.
- R11: A reserved field always holds and reads back its reset value. It ignores software writes and all hardware inputs.
- R12: On every non-reserved bit, the hardware inputs override the software effect of the same cycle. `hw_set` beats `hw_clr`, which beats the `hw_we`/`hw_wdata` load.
- R13: Without `sel`, the enables have no effect. When no read is active, `rdata` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sel | input | 1 | Bus select |
| wr_en | input | 1 | Write enable |
| rd_en | input | 1 | Read enable |
| wdata | input | NUM_FIELDS*FIELD_W | Write data |
| wmask | input | NUM_FIELDS*FIELD_W | Per-bit write mask |
| rdata | output | NUM_FIELDS*FIELD_W | Read data, valid while reading |
| hw_set | input | NUM_FIELDS*FIELD_W | Hardware per-bit set |
| hw_clr | input | NUM_FIELDS*FIELD_W | Hardware per-bit clear |
| hw_we | input | NUM_FIELDS*FIELD_W | Hardware per-bit load enable |
| hw_wdata | input | NUM_FIELDS*FIELD_W | Hardware load value |
| field_q | output | NUM_FIELDS*FIELD_W | Stored field values |
| trig | output | NUM_FIELDS*FIELD_W | One-cycle trigger pulses |

## Verification
The bench builds the bank with thirteen fields of two bits each, one field per policy code in code order, and a mixed reset pattern. Every policy therefore runs side by side under the same bus traffic. Two-bit fields bring within reach the cases where a write mask covers only part of a write-once field, where one bit toggles while its neighbour does not, and where a hardware set and a software clear collide on one bit while the other bit is cleared. Random traffic with sparse hardware events and occasional resets also re-arms the write-once lock many times.

// File: rtl/mpr_pkg.sv
package mpr_pkg;

    typedef enum logic [3:0] {
        ACC_RW    = 4'd0,
        ACC_RO    = 4'd1,
        ACC_WO    = 4'd2,
        ACC_CLR0  = 4'd3,
        ACC_CLR1  = 4'd4,
        ACC_CLRW  = 4'd5,
        ACC_CLRRD = 4'd6,
        ACC_SETRD = 4'd7,
        ACC_SET1  = 4'd8,
        ACC_ONCE  = 4'd9,
        ACC_TOG   = 4'd10,
        ACC_TRIG  = 4'd11,
        ACC_RSVD  = 4'd12
    } acc_e;

    localparam int unsigned CODE_W = 4;

    typedef struct packed {
        logic hit;     // masked bus write on this bit
        logic data;    // write data bit
        logic rd;      // bus read of the register
        logic locked;  // write-once lock of the owning field
    } sw_bit_t;

    typedef struct packed {
        logic set;
        logic clr;
        logic we;
        logic val;
    } hw_bit_t;

    function automatic logic sw_next(acc_e pol, logic cur, sw_bit_t s);
        logic v;
        v = cur;
        unique case (pol)
            ACC_RW, ACC_WO: if (s.hit)               v = s.data;
            ACC_CLR0:       if (s.hit && !s.data)    v = 1'b0;
            ACC_CLR1:       if (s.hit && s.data)     v = 1'b0;
            ACC_CLRW:       if (s.hit)               v = 1'b0;
            ACC_CLRRD:      if (s.rd)                v = 1'b0;
            ACC_SETRD:      if (s.rd)                v = 1'b1;
            ACC_SET1:       if (s.hit && s.data)     v = 1'b1;
            ACC_ONCE:       if (s.hit && !s.locked)  v = s.data;
            ACC_TOG:        if (s.hit && s.data)     v = ~cur;
            default:        v = cur;
        endcase
        return v;
    endfunction

    function automatic logic hw_next(logic sw_val, hw_bit_t h);
        logic v;
        v = sw_val;
        if (h.we)  v = h.val;
        if (h.clr) v = 1'b0;
        if (h.set) v = 1'b1;
        return v;
    endfunction

    function automatic logic shows_reset(acc_e pol);
        return (pol == ACC_WO) || (pol == ACC_RSVD);
    endfunction

endpackage

// File: rtl/mpr_sw_policy.sv
module mpr_sw_policy
    import mpr_pkg::*;
#(
    parameter int unsigned W   = 2,
    parameter acc_e        POL = ACC_RW
) (
    input  logic [W-1:0] cur,
    input  logic         wr,
    input  logic         rd,
    input  logic         locked,
    input  logic [W-1:0] wmask,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] nxt
);
    for (genvar b = 0; b < W; b++) begin : g_bit
        sw_bit_t req;
        always_comb begin
            req.hit    = wr & wmask[b];
            req.data   = wdata[b];
            req.rd     = rd;
            req.locked = locked;
        end
        assign nxt[b] = sw_next(POL, cur[b], req);
    end
endmodule

// File: rtl/mpr_hw_merge.sv
module mpr_hw_merge
    import mpr_pkg::*;
#(
    parameter int unsigned W = 2
) (
    input  logic [W-1:0] sw_val,
    input  logic [W-1:0] hw_set,
    input  logic [W-1:0] hw_clr,
    input  logic [W-1:0] hw_we,
    input  logic [W-1:0] hw_wdata,
    output logic [W-1:0] nxt
);
    for (genvar b = 0; b < W; b++) begin : g_bit
        hw_bit_t h;
        always_comb begin
            h.set = hw_set[b];
            h.clr = hw_clr[b];
            h.we  = hw_we[b];
            h.val = hw_wdata[b];
        end
        assign nxt[b] = hw_next(sw_val[b], h);
    end
endmodule

// File: rtl/mpr_field.sv
module mpr_field
    import mpr_pkg::*;
#(
    parameter int unsigned W   = 2,
    parameter acc_e        POL = ACC_RW,
    parameter logic [W-1:0] RST = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr,
    input  logic         rd,
    input  logic [W-1:0] wmask,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] hw_set,
    input  logic [W-1:0] hw_clr,
    input  logic [W-1:0] hw_we,
    input  logic [W-1:0] hw_wdata,
    output logic [W-1:0] q,
    output logic [W-1:0] rd_view,
    output logic [W-1:0] trig
);
    localparam bit IS_ONCE = (POL == ACC_ONCE);
    localparam bit IS_TRIG = (POL == ACC_TRIG);
    localparam bit IS_RSVD = (POL == ACC_RSVD);

    logic [W-1:0] q_r, sw_nxt, hw_nxt, q_nxt, trig_r;
    logic         lock_r, lock_nxt;

    mpr_sw_policy #(.W(W), .POL(POL)) u_sw (
        .cur    (q_r),
        .wr     (wr),
        .rd     (rd),
        .locked (lock_r),
        .wmask  (wmask),
        .wdata  (wdata),
        .nxt    (sw_nxt)
    );

    mpr_hw_merge #(.W(W)) u_hw (
        .sw_val   (sw_nxt),
        .hw_set   (hw_set),
        .hw_clr   (hw_clr),
        .hw_we    (hw_we),
        .hw_wdata (hw_wdata),
        .nxt      (hw_nxt)
    );

    always_comb begin
        q_nxt    = IS_RSVD ? RST : hw_nxt;
        lock_nxt = IS_ONCE ? (lock_r | (wr & (|wmask))) : 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q_r    <= RST;
            lock_r <= 1'b0;
            trig_r <= '0;
        end else begin
            q_r    <= q_nxt;
            lock_r <= lock_nxt;
            trig_r <= (IS_TRIG && wr) ? (wmask & wdata) : '0;
        end
    end

    assign q       = q_r;
    assign rd_view = shows_reset(POL) ? RST : q_r;
    assign trig    = trig_r;
endmodule

// File: rtl/multipolicy_reg.sv
module multipolicy_reg
    import mpr_pkg::*;
#(
    parameter int unsigned NUM_FIELDS = 13,
    parameter int unsigned FIELD_W    = 2,
    parameter logic [NUM_FIELDS*CODE_W-1:0] POLICY_VEC = {
        4'd12, 4'd11, 4'd10, 4'd9, 4'd8, 4'd7, 4'd6,
        4'd5,  4'd4,  4'd3,  4'd2, 4'd1, 4'd0},
    parameter logic [NUM_FIELDS*FIELD_W-1:0] RESET_VAL = '0
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          sel,
    input  logic                          wr_en,
    input  logic                          rd_en,
    input  logic [NUM_FIELDS*FIELD_W-1:0] wdata,
    input  logic [NUM_FIELDS*FIELD_W-1:0] wmask,
    output logic [NUM_FIELDS*FIELD_W-1:0] rdata,
    input  logic [NUM_FIELDS*FIELD_W-1:0] hw_set,
    input  logic [NUM_FIELDS*FIELD_W-1:0] hw_clr,
    input  logic [NUM_FIELDS*FIELD_W-1:0] hw_we,
    input  logic [NUM_FIELDS*FIELD_W-1:0] hw_wdata,
    output logic [NUM_FIELDS*FIELD_W-1:0] field_q,
    output logic [NUM_FIELDS*FIELD_W-1:0] trig
);
    localparam int unsigned DW = NUM_FIELDS * FIELD_W;

    logic          bus_wr, bus_rd;
    logic [DW-1:0] view;

    assign bus_wr = sel & wr_en;
    assign bus_rd = sel & rd_en;

    for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_field
        localparam acc_e POL = acc_e'(POLICY_VEC[f*CODE_W +: CODE_W]);
        mpr_field #(
            .W   (FIELD_W),
            .POL (POL),
            .RST (RESET_VAL[f*FIELD_W +: FIELD_W])
        ) u_field (
            .clk      (clk),
            .rst      (rst),
            .wr       (bus_wr),
            .rd       (bus_rd),
            .wmask    (wmask[f*FIELD_W +: FIELD_W]),
            .wdata    (wdata[f*FIELD_W +: FIELD_W]),
            .hw_set   (hw_set[f*FIELD_W +: FIELD_W]),
            .hw_clr   (hw_clr[f*FIELD_W +: FIELD_W]),
            .hw_we    (hw_we[f*FIELD_W +: FIELD_W]),
            .hw_wdata (hw_wdata[f*FIELD_W +: FIELD_W]),
            .q        (field_q[f*FIELD_W +: FIELD_W]),
            .rd_view  (view[f*FIELD_W +: FIELD_W]),
            .trig     (trig[f*FIELD_W +: FIELD_W])
        );
    end

    assign rdata = bus_rd ? view : '0;
endmodule

// File: rtl/mpr_checker.sv
module mpr_checker
    import mpr_pkg::*;
#(
    parameter int unsigned NUM_FIELDS = 13,
    parameter int unsigned FIELD_W    = 2,
    parameter logic [NUM_FIELDS*CODE_W-1:0] POLICY_VEC = '0,
    parameter logic [NUM_FIELDS*FIELD_W-1:0] RESET_VAL = '0
) (
    input logic                          clk,
    input logic                          rst,
    input logic                          sel,
    input logic                          wr_en,
    input logic                          rd_en,
    input logic [NUM_FIELDS*FIELD_W-1:0] rdata,
    input logic [NUM_FIELDS*FIELD_W-1:0] hw_set,
    input logic [NUM_FIELDS*FIELD_W-1:0] hw_clr,
    input logic [NUM_FIELDS*FIELD_W-1:0] hw_we,
    input logic [NUM_FIELDS*FIELD_W-1:0] field_q,
    input logic [NUM_FIELDS*FIELD_W-1:0] trig
);
    AST_IDLE_RDATA_ZERO: assert property (@(posedge clk) disable iff (rst)
        !(sel && rd_en) |-> (rdata == '0)); // R13

    AST_NO_ACCESS_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (!sel && hw_set == '0 && hw_clr == '0 && hw_we == '0) |=> $stable(field_q)); // R13

    AST_TRIG_NEEDS_WRITE: assert property (@(posedge clk) disable iff (rst)
        (trig != '0) |-> $past(sel && wr_en)); // R10

    for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_chk
        localparam logic [CODE_W-1:0] CODE = POLICY_VEC[f*CODE_W +: CODE_W];
        if (CODE != 4'(ACC_RSVD)) begin : g_hw
            AST_HW_SET_WINS: assert property (@(posedge clk) disable iff (rst)
                (hw_set[f*FIELD_W +: FIELD_W] != '0) |=>
                ((field_q[f*FIELD_W +: FIELD_W] & $past(hw_set[f*FIELD_W +: FIELD_W]))
                  == $past(hw_set[f*FIELD_W +: FIELD_W]))); // R12
        end
        if (CODE == 4'(ACC_WO)) begin : g_wo
            AST_WO_READS_RESET: assert property (@(posedge clk) disable iff (rst)
                (sel && rd_en) |-> (rdata[f*FIELD_W +: FIELD_W]
                                    == RESET_VAL[f*FIELD_W +: FIELD_W])); // R3
        end
        if (CODE == 4'(ACC_CLRRD)) begin : g_crd
            AST_CLEAR_AFTER_READ: assert property (@(posedge clk) disable iff (rst)
                (sel && rd_en && hw_set[f*FIELD_W +: FIELD_W] == '0
                     && hw_we[f*FIELD_W +: FIELD_W] == '0)
                |=> (field_q[f*FIELD_W +: FIELD_W] == '0)); // R6
        end
    end
endmodule

bind multipolicy_reg mpr_checker #(
    .NUM_FIELDS (NUM_FIELDS),
    .FIELD_W    (FIELD_W),
    .POLICY_VEC (POLICY_VEC),
    .RESET_VAL  (RESET_VAL)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .sel      (sel),
    .wr_en    (wr_en),
    .rd_en    (rd_en),
    .rdata    (rdata),
    .hw_set   (hw_set),
    .hw_clr   (hw_clr),
    .hw_we    (hw_we),
    .field_q  (field_q),
    .trig     (trig)
);

// File: tb/multipolicy_reg_tb.sv
`timescale 1ns/1ps
module multipolicy_reg_tb;
    localparam int NF = 13;
    localparam int FW = 2;
    localparam int DW = NF * FW;
    localparam logic [NF*4-1:0] POL = {
        4'd12, 4'd11, 4'd10, 4'd9, 4'd8, 4'd7, 4'd6,
        4'd5,  4'd4,  4'd3,  4'd2, 4'd1, 4'd0};
    localparam logic [DW-1:0] RST = 26'h1A5_C3E9;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sel = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
    logic [DW-1:0] wdata = '0, wmask = '0;
    logic [DW-1:0] hw_set = '0, hw_clr = '0, hw_we = '0, hw_wdata = '0;
    logic [DW-1:0] rdata, field_q, trig;

    always #2.5 clk = ~clk;

    multipolicy_reg #(
        .NUM_FIELDS (NF),
        .FIELD_W    (FW),
        .POLICY_VEC (POL),
        .RESET_VAL  (RST)
    ) u_dut (
        .clk(clk), .rst(rst), .sel(sel), .wr_en(wr_en), .rd_en(rd_en),
        .wdata(wdata), .wmask(wmask), .rdata(rdata),
        .hw_set(hw_set), .hw_clr(hw_clr), .hw_we(hw_we), .hw_wdata(hw_wdata),
        .field_q(field_q), .trig(trig)
    );

    int checks = 0;
    int fails  = 0;
    bit started = 0;
    bit finished = 0;

    // reference model state
    logic [DW-1:0] m_q;
    logic [NF-1:0] m_lock;
    logic [DW-1:0] m_trig;

    function automatic int pol_of(int f);
        return int'(POL[f*4 +: 4]);
    endfunction

    function automatic string req_of(int p);
        case (p)
            0, 1:    return "R2";
            2:       return "R3";
            3, 4:    return "R4";
            5:       return "R5";
            6, 7:    return "R6";
            8:       return "R7";
            9:       return "R8";
            10:      return "R9";
            11:      return "R10";
            default: return "R11";
        endcase
    endfunction

    always @(posedge clk) begin
        logic [DW-1:0] nq, nt;
        logic [NF-1:0] nl;
        started <= 1'b1;
        if (rst) begin
            m_q    <= RST;
            m_lock <= '0;
            m_trig <= '0;
        end else begin
            nq = m_q; nt = '0; nl = m_lock;
            for (int f = 0; f < NF; f++) begin
                int p;
                bit wrf;
                p = pol_of(f);
                wrf = 0;
                for (int b = 0; b < FW; b++) begin
                    int i;
                    bit hit, d, rd;
                    i = f*FW + b;
                    hit = sel && wr_en && wmask[i];
                    d = wdata[i];
                    rd = sel && rd_en;
                    if (hit) wrf = 1;
                    if (p == 0 || p == 2) begin if (hit) nq[i] = d; end
                    else if (p == 3) begin if (hit && !d) nq[i] = 0; end
                    else if (p == 4) begin if (hit && d) nq[i] = 0; end
                    else if (p == 5) begin if (hit) nq[i] = 0; end
                    else if (p == 6) begin if (rd) nq[i] = 0; end
                    else if (p == 7) begin if (rd) nq[i] = 1; end
                    else if (p == 8) begin if (hit && d) nq[i] = 1; end
                    else if (p == 9) begin if (hit && !m_lock[f]) nq[i] = d; end
                    else if (p == 10) begin if (hit && d) nq[i] = ~m_q[i]; end
                    else if (p == 11) begin if (hit && d) nt[i] = 1; end
                    if (p != 12) begin
                        if (hw_we[i])  nq[i] = hw_wdata[i];
                        if (hw_clr[i]) nq[i] = 0;
                        if (hw_set[i]) nq[i] = 1;
                    end
                end
                if (p == 9 && wrf) nl[f] = 1;
            end
            m_q <= nq; m_lock <= nl; m_trig <= nt;
        end
    end

    // cycle-by-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (started && !finished) begin
            for (int f = 0; f < NF; f++) begin
                int p;
                logic [FW-1:0] eq, er, et;
                p = pol_of(f);
                eq = (p == 12) ? RST[f*FW +: FW] : m_q[f*FW +: FW];
                er = (sel && rd_en) ? ((p == 2 || p == 12) ? RST[f*FW +: FW]
                                                          : m_q[f*FW +: FW]) : '0;
                et = m_trig[f*FW +: FW];
                checks++;
                if (field_q[f*FW +: FW] !== eq || rdata[f*FW +: FW] !== er
                    || trig[f*FW +: FW] !== et) begin
                    fails++;
                    $display("FAIL %s field %0d: q=%b rd=%b trig=%b expected q=%b rd=%b trig=%b",
                             req_of(p), f, field_q[f*FW +: FW], rdata[f*FW +: FW],
                             trig[f*FW +: FW], eq, er, et);
                end
            end
        end
    end

    task automatic chk(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic idle();
        sel = 0; wr_en = 0; rd_en = 0; wdata = '0; wmask = '0;
        hw_set = '0; hw_clr = '0; hw_we = '0; hw_wdata = '0;
    endtask

    task automatic bus_write(logic [DW-1:0] d, logic [DW-1:0] m);
        idle(); sel = 1; wr_en = 1; wdata = d; wmask = m;
        tick();
    endtask

    task automatic bus_read();
        idle(); sel = 1; rd_en = 1;
        tick();
    endtask

    task automatic do_reset();
        idle(); rst = 1;
        tick(); tick();
        rst = 0;
    endtask

    localparam logic [DW-1:0] ALL = '1;

    initial begin
        logic [DW-1:0] snap;
        idle();
        do_reset();
        @(negedge clk);
        // r1_ reset state
        chk("R1 reset q", field_q, RST);
        chk("R1 reset trig", trig, '0);
        chk("R1 idle rdata", rdata, '0);

        // R13: enables without select do nothing
        snap = field_q;
        idle(); wr_en = 1; rd_en = 1; wdata = ~RST; wmask = ALL;
        tick();
        @(negedge clk);
        chk("R13 unselected access", field_q, snap);
        chk("R13 rdata without read", rdata, '0);

        // R8: partial-mask write locks the write-once field (field 9, bits 19:18)
        bus_write(26'h0 | (2'b01 << 18), 26'h0 | (2'b01 << 18));
        bus_write(26'h0 | (2'b10 << 18), 26'h0 | (2'b11 << 18));
        @(negedge clk);
        chk("R8 write-once locked", field_q[19:18], {RST[19], 1'b1});

        // R10: trigger pulse (field 11, bits 23:22)
        bus_write(26'h0 | (2'b11 << 22), 26'h0 | (2'b11 << 22));
        @(negedge clk);
        chk("R10 trig pulse", trig[23:22], 2'b11);
        chk("R10 stored unchanged", field_q[23:22], RST[23:22]);
        idle(); tick();
        @(negedge clk);
        chk("R10 pulse ends", trig[23:22], 2'b00);

        // R12: hw set on field 4 (clear-on-1) against a software clear
        idle(); sel = 1; wr_en = 1; wdata = ALL; wmask = ALL;
        hw_set = 26'h0 | (2'b01 << 8);
        tick();
        @(negedge clk);
        chk("R12 hw set beats sw clear", field_q[9:8], 2'b01);

        // R6: read returns pre-effect value, then clears
        bus_write('0, '0);
        bus_read();
        bus_read();

        // assorted directed patterns
        bus_write(ALL, ALL);
        bus_read();
        bus_write('0, ALL);
        bus_read();
        bus_write(26'h2AA_AAAA, 26'h155_5555);
        bus_write(26'h155_5555, ALL);
        bus_read();

        // random traffic with sparse hardware events and occasional resets
        for (int n = 0; n < 6000; n++) begin
            idle();
            if ($urandom_range(0, 199) == 0) begin
                do_reset();
            end else begin
                sel   = ($urandom_range(0, 3) != 0);
                wr_en = $urandom_range(0, 1);
                rd_en = ($urandom_range(0, 2) == 0);
                wdata = DW'($urandom);
                wmask = ($urandom_range(0, 1) != 0) ? ALL : DW'($urandom);
                if ($urandom_range(0, 7) == 0) hw_set = DW'($urandom) & DW'($urandom);
                if ($urandom_range(0, 7) == 0) hw_clr = DW'($urandom) & DW'($urandom);
                if ($urandom_range(0, 7) == 0) begin
                    hw_we = DW'($urandom);
                    hw_wdata = DW'($urandom);
                end
                tick();
            end
        end
        idle(); tick();
        @(negedge clk);
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!finished) begin
            finished = 1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule